// File: doc/BRIEF.md
# UART Line Status Tracker

This unit keeps the line and modem status of a UART. The receive FIFO, the transmit registers and the register-read logic around it report events to it. It does not hold character data. It follows the receive FIFO through push and pop events, each with an error tag, and through a strobe that marks a new character arriving at the FIFO head. It follows the transmit path through a holding-register write strobe, a hand-over strobe and a shift-register busy level. From these it builds an 8-bit line status word that register-read logic can return as it stands.

Framing error and break describe the character at the FIFO head. They stay set until software reads the line status. The FIFO-error flag works differently. It is backed by a counter of error-tagged characters still in the FIFO, so a status read clears the flag only once that count reaches zero. The modem inputs are synchronised one line at a time. The modem status word holds the current level of each line in its upper half and a sticky change flag for each line in its lower half. A read of that word clears the change flags.

Top module: `uart_lsr_track`

## Requirements
- R1: After reset, `lsr_status` is 8'h60 (transmit-holding-empty bit 5 and transmitter-empty bit 6 set, all others 0), and `msr_status` is 0.
- R2: A pulse on `rx_head_new` sets `lsr_status[3]` (framing error) when `rx_head_fe` is 1, and sets `lsr_status[4]` (break) when `rx_head_bi` is 1. The bit is visible one cycle after the pulse.
- R3: A pulse on `lsr_rd` clears bits 3 and 4 one cycle later. A bit whose set condition from R2 is present in the same cycle stays at 1.
- R4: `lsr_status[5]` clears one cycle after `thr_wr` and sets one cycle after `thr_xfer`. When both arrive in the same cycle, the bit becomes 0.
- R5: `lsr_status[6]` is 1 exactly when `lsr_status[5]` is 1 and `tsr_busy` is 0.
- R6: While `fifo_en` is 1, a push (`rx_push`) carrying any of the framing, parity or break tags sets `lsr_status[7]` one cycle later.
- R7: The unit counts error-tagged characters in the FIFO. Each errored push adds one, and each pop with `rx_pop_err` subtracts one. A line status read clears `lsr_status[7]` only when the count after that cycle's push and pop is zero.
- R8: While `fifo_en` is 0, `lsr_status[7]` reads 0, the count is emptied and pushes are not counted. After re-enabling, the flag stays 0 until a new errored push arrives.
- R9: `msr_status[NUM_LINES+i]` shows modem line `i` after `SYNC_STAGES` clock edges (2 by default).
- R10: Either edge of modem line `i` sets `msr_status[i]`, visible `SYNC_STAGES+1` edges after the input changes. `msr_rd` clears it, but an edge detected in the same cycle as the read wins.
- R11: `lsr_status[2:0]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Receive FIFO enabled |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_push_fe | input | 1 | Pushed character has a framing error |
| rx_push_pe | input | 1 | Pushed character has a parity error |
| rx_push_bi | input | 1 | Pushed character is a break |
| rx_pop | input | 1 | Character removed from the receive FIFO |
| rx_pop_err | input | 1 | Popped character carried an error tag |
| rx_head_new | input | 1 | A new character is now at the FIFO head |
| rx_head_fe | input | 1 | Head character has a framing error |
| rx_head_bi | input | 1 | Head character is a break |
| thr_wr | input | 1 | Write to the transmit holding register |
| thr_xfer | input | 1 | Holding register handed to the shift register |
| tsr_busy | input | 1 | Transmit shift register holds data |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| modem_in | input | NUM_LINES | Asynchronous modem input lines |
| lsr_status | output | 8 | Line status word |
| msr_status | output | 2*NUM_LINES | Modem levels (upper half) and change flags (lower half) |

## Verification
The bench fills the error count to every depth from one to full. It then drains the count with reads that share a cycle with a pop. A design that cleared the FIFO-error flag on any read, or that compared the count before the pop, would drop the flag one read too early or keep it one read too long. Every read against a new event is tested as a same-cycle collision, on the head flags, on an errored push and on a modem edge; a design that let the clear win would lose an event that software never saw. The sweep over every holding-register state and strobe pair, with the shift register idle or busy, exposes a wrong write-versus-hand-over priority or a transmitter-empty bit that ignores the shift register.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

   localparam int LSR_W        = 8;
   localparam int LSR_FE_POS   = 3;
   localparam int LSR_BI_POS   = 4;
   localparam int LSR_THRE_POS = 5;
   localparam int LSR_TEMT_POS = 6;
   localparam int LSR_RXFE_POS = 7;

   typedef struct packed {
      logic fe;
      logic pe;
      logic bi;
   } rx_tag_t;

   function automatic logic tag_has_err(rx_tag_t t);
      return t.fe | t.pe | t.bi;
   endfunction

endpackage

// File: rtl/uart_lsr_rx_err.sv
module uart_lsr_rx_err
   import uart_lsr_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter bit FIFO_PRESENT = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    fifo_en,
   input  logic    push,
   input  rx_tag_t push_tag,
   input  logic    pop,
   input  logic    pop_err,
   input  logic    head_new,
   input  logic    head_fe,
   input  logic    head_bi,
   input  logic    lsr_rd,
   output logic    fe,
   output logic    bi,
   output logic    rxfe
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic fe_q, bi_q;
   logic fe_set, bi_set;

   assign fe_set = head_new & head_fe;
   assign bi_set = head_new & head_bi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fe_q <= 1'b0;
         bi_q <= 1'b0;
      end else begin
         if (fe_set)      fe_q <= 1'b1;
         else if (lsr_rd) fe_q <= 1'b0;
         if (bi_set)      bi_q <= 1'b1;
         else if (lsr_rd) bi_q <= 1'b0;
      end
   end

   assign fe = fe_q;
   assign bi = bi_q;

   p_fe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !fe_set) |=> !fe_q);
   p_head_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_set || bi_set) |=> (fe_q || bi_q));

   generate
      if (FIFO_PRESENT) begin : g_fifo
         logic [CNT_W-1:0] cnt_q, cnt_next;
         logic             rxfe_q;
         logic             err_push, err_pop;

         assign err_push = fifo_en & push & tag_has_err(push_tag);
         assign err_pop  = fifo_en & pop & pop_err;

         always_comb begin
            cnt_next = cnt_q;
            if (err_push) cnt_next = cnt_next + CNT_W'(1);
            if (err_pop)  cnt_next = cnt_next - CNT_W'(1);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               rxfe_q <= 1'b0;
            end else if (!fifo_en) begin
               cnt_q  <= '0;
               rxfe_q <= 1'b0;
            end else begin
               cnt_q <= cnt_next;
               if (err_push)    rxfe_q <= 1'b1;
               else if (lsr_rd) rxfe_q <= (cnt_next != '0);
            end
         end

         assign rxfe = fifo_en & rxfe_q;

         p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !((cnt_q == CNT_MAX) && err_push && !err_pop));
         p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !((cnt_q == '0) && err_pop && !err_push));
         p_rxfe_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            err_push |=> rxfe_q);
         p_fifo_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !fifo_en |=> (cnt_q == '0) && !rxfe_q);
      end else begin : g_nofifo
         assign rxfe = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/uart_lsr_tx_stat.sv
module uart_lsr_tx_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_wr,
   input  logic thr_xfer,
   input  logic tsr_busy,
   output logic thre,
   output logic temt
);

   logic thre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        thre_q <= 1'b1;
      else if (thr_wr)   thre_q <= 1'b0;
      else if (thr_xfer) thre_q <= 1'b1;
   end

   assign thre = thre_q;
   assign temt = thre_q & ~tsr_busy;

   p_thre_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !thre);
   p_thre_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_xfer && !thr_wr) |=> thre);

   always_comb begin
      if (rst_n) begin
         p_temt_r5: assert (!temt || thre);
      end
   end

endmodule

// File: rtl/uart_lsr_modem_line.sv
module uart_lsr_modem_line #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic clr,
   output logic level,
   output logic delta
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   delta_q;
   logic                   edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign level     = sync_q[SYNC_STAGES-1];
   assign edge_seen = level ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         delta_q <= 1'b0;
      else if (edge_seen) delta_q <= 1'b1;
      else if (clr)       delta_q <= 1'b0;
   end

   assign delta = delta_q;

   p_delta_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> delta);
   p_delta_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !edge_seen) |=> !delta);

endmodule

// File: rtl/uart_lsr_track.sv
module uart_lsr_track
   import uart_lsr_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int NUM_LINES    = 4,
   parameter int SYNC_STAGES  = 2,
   parameter bit FIFO_PRESENT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fifo_en,
   input  logic                   rx_push,
   input  logic                   rx_push_fe,
   input  logic                   rx_push_pe,
   input  logic                   rx_push_bi,
   input  logic                   rx_pop,
   input  logic                   rx_pop_err,
   input  logic                   rx_head_new,
   input  logic                   rx_head_fe,
   input  logic                   rx_head_bi,
   input  logic                   thr_wr,
   input  logic                   thr_xfer,
   input  logic                   tsr_busy,
   input  logic                   lsr_rd,
   input  logic                   msr_rd,
   input  logic [NUM_LINES-1:0]   modem_in,
   output logic [LSR_W-1:0]       lsr_status,
   output logic [2*NUM_LINES-1:0] msr_status
);

   initial begin : p_param_chk
      assert (DEPTH >= 1 && DEPTH <= 1024);
      assert (NUM_LINES >= 1 && NUM_LINES <= 8);
      assert (SYNC_STAGES >= 2 && SYNC_STAGES <= 4);
   end

   rx_tag_t push_tag;
   logic    fe, bi, rxfe, thre, temt;
   logic [NUM_LINES-1:0] lvl, dlt;

   assign push_tag = '{fe: rx_push_fe, pe: rx_push_pe, bi: rx_push_bi};

   uart_lsr_rx_err #(.DEPTH(DEPTH), .FIFO_PRESENT(FIFO_PRESENT)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_en  (fifo_en),
      .push     (rx_push),
      .push_tag (push_tag),
      .pop      (rx_pop),
      .pop_err  (rx_pop_err),
      .head_new (rx_head_new),
      .head_fe  (rx_head_fe),
      .head_bi  (rx_head_bi),
      .lsr_rd   (lsr_rd),
      .fe       (fe),
      .bi       (bi),
      .rxfe     (rxfe)
   );

   uart_lsr_tx_stat u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .thr_wr   (thr_wr),
      .thr_xfer (thr_xfer),
      .tsr_busy (tsr_busy),
      .thre     (thre),
      .temt     (temt)
   );

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         uart_lsr_modem_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (modem_in[i]),
            .clr     (msr_rd),
            .level   (lvl[i]),
            .delta   (dlt[i])
         );
      end
   endgenerate

   always_comb begin
      lsr_status               = '0;
      lsr_status[LSR_FE_POS]   = fe;
      lsr_status[LSR_BI_POS]   = bi;
      lsr_status[LSR_THRE_POS] = thre;
      lsr_status[LSR_TEMT_POS] = temt;
      lsr_status[LSR_RXFE_POS] = rxfe;
   end

   assign msr_status = {lvl, dlt};

   p_rxfe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> !lsr_status[LSR_RXFE_POS]);
   p_low_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_status[2:0] == 3'b000);

endmodule

// File: tb/uart_lsr_track_tb_top.sv
`timescale 1ns/100ps
module uart_lsr_track_tb_top;

   localparam int DEPTH = 4;
   localparam int NL    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en = 1'b1;
   logic rx_push = 0, rx_push_fe = 0, rx_push_pe = 0, rx_push_bi = 0;
   logic rx_pop = 0, rx_pop_err = 0;
   logic rx_head_new = 0, rx_head_fe = 0, rx_head_bi = 0;
   logic thr_wr = 0, thr_xfer = 0, tsr_busy = 0;
   logic lsr_rd = 0, msr_rd = 0;
   logic [NL-1:0]   modem_in = '0;
   logic [7:0]      lsr_status;
   logic [2*NL-1:0] msr_status;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_lsr_track #(.DEPTH(DEPTH), .NUM_LINES(NL), .SYNC_STAGES(2), .FIFO_PRESENT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
      .rx_push(rx_push), .rx_push_fe(rx_push_fe), .rx_push_pe(rx_push_pe), .rx_push_bi(rx_push_bi),
      .rx_pop(rx_pop), .rx_pop_err(rx_pop_err),
      .rx_head_new(rx_head_new), .rx_head_fe(rx_head_fe), .rx_head_bi(rx_head_bi),
      .thr_wr(thr_wr), .thr_xfer(thr_xfer), .tsr_busy(tsr_busy),
      .lsr_rd(lsr_rd), .msr_rd(msr_rd), .modem_in(modem_in),
      .lsr_status(lsr_status), .msr_status(msr_status)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_strobes();
      rx_push = 0; rx_push_fe = 0; rx_push_pe = 0; rx_push_bi = 0;
      rx_pop = 0; rx_pop_err = 0; rx_head_new = 0; rx_head_fe = 0; rx_head_bi = 0;
      thr_wr = 0; thr_xfer = 0; lsr_rd = 0; msr_rd = 0;
   endtask

   task automatic do_lsr_read();
      lsr_rd = 1; tick(); lsr_rd = 0;
   endtask

   initial begin : watchdog
      #500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      check("R1 lsr", lsr_status, 32'h60);
      check("R1 msr", msr_status, 32'h0);

      // R2/R3/R11 head flag sweep over all tag combinations
      for (int k = 0; k < 4; k++) begin
         rx_head_new = 1; rx_head_fe = k[0]; rx_head_bi = k[1];
         tick(); clear_strobes();
         check("R2 fe", lsr_status[3], k[0]);
         check("R2 bi", lsr_status[4], k[1]);
         check("R11 low bits", lsr_status[2:0], 0);
         do_lsr_read();
         check("R3 cleared", lsr_status[4:3], 0);
      end
      // R3 set beats read in same cycle
      rx_head_new = 1; rx_head_fe = 1; lsr_rd = 1;
      tick(); clear_strobes();
      check("R3 set wins", lsr_status[3], 1);
      do_lsr_read();
      check("R3 clear after", lsr_status[3], 0);

      // R4/R5 sweep: initial state, write, hand-over, shift busy
      for (int s = 0; s < 2; s++)
         for (int w = 0; w < 2; w++)
            for (int x = 0; x < 2; x++)
               for (int b = 0; b < 2; b++) begin
                  if (s == 1) thr_xfer = 1; else thr_wr = 1;
                  tick(); clear_strobes();
                  thr_wr = w[0]; thr_xfer = x[0]; tsr_busy = b[0];
                  tick(); clear_strobes();
                  begin
                     logic et;
                     et = w[0] ? 1'b0 : (x[0] ? 1'b1 : s[0]);
                     check("R4 thre", lsr_status[5], et);
                     check("R5 temt", lsr_status[6], et & ~b[0]);
                  end
                  tsr_busy = 0;
               end

      // R6/R7 fill to every depth then drain with read+pop collisions
      for (int n = 1; n <= DEPTH; n++) begin
         for (int j = 0; j < n; j++) begin
            rx_push = 1;
            rx_push_fe = (j % 3 == 0); rx_push_pe = (j % 3 == 1); rx_push_bi = (j % 3 == 2);
            tick(); clear_strobes();
            check("R6 rxfe set", lsr_status[7], 1);
         end
         // clean pushes and pops leave the flag alone
         rx_push = 1; tick(); clear_strobes();
         rx_pop = 1; lsr_rd = 1; tick(); clear_strobes();
         check("R7 clean pop read keeps", lsr_status[7], 1);
         for (int i = n; i >= 1; i--) begin
            rx_pop = 1; rx_pop_err = 1; lsr_rd = 1;
            tick(); clear_strobes();
            check("R7 drain", lsr_status[7], (i > 1) ? 1 : 0);
         end
      end
      // R7 errored push beats a read
      rx_push = 1; rx_push_pe = 1; lsr_rd = 1;
      tick(); clear_strobes();
      check("R7 push beats read", lsr_status[7], 1);
      // R7 read with count still 1 keeps flag
      do_lsr_read();
      check("R7 count nonzero keeps", lsr_status[7], 1);

      // R8 disable clears, ignores pushes, stays clear after re-enable
      fifo_en = 0;
      #0.5;
      check("R8 masked", lsr_status[7], 0);
      rx_push = 1; rx_push_bi = 1;
      tick(); clear_strobes();
      check("R8 disabled push", lsr_status[7], 0);
      fifo_en = 1;
      tick();
      check("R8 after enable", lsr_status[7], 0);
      rx_push = 1; rx_push_fe = 1; tick(); clear_strobes();
      rx_pop = 1; rx_pop_err = 1; lsr_rd = 1; tick(); clear_strobes();
      check("R8 count restarted", lsr_status[7], 0);

      // R9/R10 each line, both edges
      for (int i = 0; i < NL; i++)
         for (int v = 1; v >= 0; v--) begin
            modem_in[i] = v[0];
            tick(); tick();
            check("R9 level", msr_status[NL+i], v);
            tick();
            check("R10 delta", msr_status[NL-1:0], 1 << i);
            msr_rd = 1; tick(); clear_strobes();
            check("R10 read clears", msr_status[NL-1:0], 0);
         end
      // R10 edge beats read
      modem_in[0] = 1;
      tick(); tick();
      msr_rd = 1; tick(); clear_strobes();
      check("R10 edge wins", msr_status[0], 1);
      msr_rd = 1; tick(); clear_strobes();
      check("R10 clear after", msr_status[0], 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule